// File: doc/BRIEF.md
# Nested-Majority Complex Gate with Defect Modes and Self-Test

This block models a five-input complex gate made of two nested three-input majority functions. The inner majority sees input A inverted, input B as is and input C inverted. The outer majority combines that result with inputs D and E. A two-bit defect selector replaces the gate's function with one of three equations. Each equation describes a cell placed off its intended position. This lets a larger test environment study how such defects look at the output.

A built-in sequencer drives the gate from one of two stored vector lists. The short list targets displacement defects. The longer list targets stuck-at faults on the pins. The sequencer applies one vector per clock. A second copy of the gate, held fault-free, produces the reference response. The sequencer compares the two outputs on each vector and keeps a sticky flag if any of them differ. When no test runs, the gate's inputs come directly from the functional input port.

Top module: `aoi_bist_gate`

## Requirements
- R1: With defect select 00, f_out = MAJ(MAJ(~A, B, ~C), D, E), where in_vec[4]=A, in_vec[3]=B, in_vec[2]=C, in_vec[1]=D, in_vec[0]=E and MAJ is the two-of-three majority.
- R2: With defect select 01, f_out = MAJ(B, D, E); inputs A and C have no effect on the output.
- R3: With defect select 10, f_out equals input B for every input vector.
- R4: With defect select 11, f_out = ~D~E + (~D + ~E)(~A B + B ~C + ~A ~B ~C).
- R5: In the fault-free mode, complementing all five inputs complements f_out.
- R6: In the fault-free mode with A=0 and D=0, f_out = E AND (B OR ~C).
- R7: A test_start seen on a rising edge while idle raises test_busy on that edge. test_sel=0 then applies ABCDE = 00000, 00001 and test_sel=1 applies 01110, 00101, 00000, 00001, one vector per clock, so test_busy stays high for exactly 2 or 4 cycles.
- R8: test_done rises on the edge that ends the last vector and stays high until the next accepted start. Reset leaves test_busy, test_done and test_detect low.
- R9: test_detect is cleared on an accepted start. It is set if any applied vector gives a gate output that differs from the fault-free response. The displacement list exposes all three defect modes, and the fault-free mode never sets it.
- R10: A test_start asserted while a test is running is ignored, so the run length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vec | input | 5 | Functional inputs, bit 4 = A down to bit 0 = E |
| defect_sel | input | 2 | 00 fault-free, 01 B-majority defect, 10 B-only defect, 11 output-cell defect |
| test_start | input | 1 | Begin a test run when idle |
| test_sel | input | 1 | 0 = displacement list, 1 = pin-fault list |
| f_out | output | 1 | Gate output (responds to the test vector while busy) |
| test_busy | output | 1 | A test run is applying vectors |
| test_done | output | 1 | The last run has finished |
| test_detect | output | 1 | Sticky mismatch flag of the last run |

## Verification
On every cycle the assertions check the sequencer's control behaviour. They check that busy and done are never high together, that a run ends in done, that the mismatch flag stays set during a run, and that a start during a run does not shorten it. They also check the OR-into-AND reduction of the fault-free gate. The equations of each defect mode, the complement symmetry and the detect outcome for every mode and vector list are shown only by the bench. The bench sweeps all 32 input vectors in all four modes and runs every mode against both lists, comparing the results with its own arithmetic model.

// File: rtl/aoi_pkg.sv
package aoi_pkg;
   typedef enum logic [1:0] {
      DEF_NONE     = 2'b00,
      DEF_B_MAJ    = 2'b01,
      DEF_B_ONLY   = 2'b10,
      DEF_OUT_CELL = 2'b11
   } defect_e;

   typedef enum logic {
      SET_DISP = 1'b0,
      SET_PIN  = 1'b1
   } tset_e;

   localparam int GATE_IN_W = 5;
   localparam int DISP_LEN  = 2;
   localparam int PIN_LEN   = 4;

   function automatic logic maj3(input logic x, input logic y, input logic z);
      return (x & y) | (x & z) | (y & z);
   endfunction
endpackage

// File: rtl/aoi_gate_core.sv
module aoi_gate_core
   import aoi_pkg::*;
#(
   parameter int  IN_W           = 5,
   parameter bit  ENABLE_DEFECTS = 1'b1
) (
   input  logic [IN_W-1:0] gin,
   input  logic [1:0]      mode,
   output logic            gout
);
   if (IN_W != GATE_IN_W) begin : g_bad_width
      $error("aoi_gate_core: IN_W must be 5");
   end

   logic a, b, c, d, e;
   logic inner, ff_out;

   assign a = gin[4];
   assign b = gin[3];
   assign c = gin[2];
   assign d = gin[1];
   assign e = gin[0];

   assign inner  = maj3(~a, b, ~c);
   assign ff_out = maj3(inner, d, e);

   if (ENABLE_DEFECTS) begin : g_defects
      always_comb begin
         unique case (defect_e'(mode))
            DEF_NONE:     gout = ff_out;
            DEF_B_MAJ:    gout = maj3(b, d, e);
            DEF_B_ONLY:   gout = b;
            DEF_OUT_CELL: gout = (~d & ~e) |
                                 ((~d | ~e) & ((~a & b) | (b & ~c) | (~a & ~b & ~c)));
            default:      gout = ff_out;
         endcase
      end
   end else begin : g_clean
      logic unused_mode;
      assign unused_mode = ^mode;
      assign gout = ff_out;
   end
endmodule

// File: rtl/aoi_vec_source.sv
module aoi_vec_source
   import aoi_pkg::*;
#(
   parameter int IN_W  = 5,
   parameter int IDX_W = 2
) (
   input  logic            set_sel,
   input  logic [IDX_W-1:0] idx,
   output logic [IN_W-1:0] vec,
   output logic            last
);
   if (IN_W != GATE_IN_W) begin : g_bad_width
      $error("aoi_vec_source: IN_W must be 5");
   end
   if ((1 << IDX_W) < PIN_LEN) begin : g_bad_idx
      $error("aoi_vec_source: IDX_W too small");
   end

   always_comb begin
      vec  = '0;
      last = 1'b0;
      if (tset_e'(set_sel) == SET_DISP) begin
         vec  = (idx == IDX_W'(0)) ? 5'b00000 : 5'b00001;
         last = (idx == IDX_W'(DISP_LEN - 1));
      end else begin
         unique case (idx)
            IDX_W'(0): vec = 5'b01110;
            IDX_W'(1): vec = 5'b00101;
            IDX_W'(2): vec = 5'b00000;
            default:   vec = 5'b00001;
         endcase
         last = (idx == IDX_W'(PIN_LEN - 1));
      end
   end
endmodule

// File: rtl/aoi_test_seq.sv
module aoi_test_seq #(
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             sel,
   input  logic             last,
   input  logic             mismatch,
   output logic             busy,
   output logic             done,
   output logic             detect,
   output logic             sel_q,
   output logic [IDX_W-1:0] idx
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         detect <= 1'b0;
         sel_q  <= 1'b0;
         idx    <= '0;
      end else if (!busy && start) begin
         busy   <= 1'b1;
         done   <= 1'b0;
         detect <= 1'b0;
         sel_q  <= sel;
         idx    <= '0;
      end else if (busy) begin
         if (mismatch) detect <= 1'b1;
         if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
            idx  <= '0;
         end else begin
            idx <= idx + IDX_W'(1);
         end
      end
   end

   assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   assert_run_ends_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && last) |=> (!busy && done));

   assert_detect_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && detect) |=> detect);

   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last && start) |=> (busy && $stable(sel_q)));
endmodule

// File: rtl/aoi_bist_gate.sv
module aoi_bist_gate
   import aoi_pkg::*;
#(
   parameter int IN_W           = 5,
   parameter bit ENABLE_DEFECTS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IN_W-1:0] in_vec,
   input  logic [1:0]      defect_sel,
   input  logic            test_start,
   input  logic            test_sel,
   output logic            f_out,
   output logic            test_busy,
   output logic            test_done,
   output logic            test_detect
);
   localparam int IDX_W = $clog2(PIN_LEN);

   if (IN_W != GATE_IN_W) begin : g_bad_width
      $error("aoi_bist_gate: IN_W must be 5");
   end

   logic [IDX_W-1:0] idx;
   logic [IN_W-1:0]  test_vec, gate_in;
   logic             last, sel_q, dut_f, ref_f;

   aoi_vec_source #(.IN_W(IN_W), .IDX_W(IDX_W)) u_src (
      .set_sel(sel_q), .idx(idx), .vec(test_vec), .last(last)
   );

   assign gate_in = test_busy ? test_vec : in_vec;

   aoi_gate_core #(.IN_W(IN_W), .ENABLE_DEFECTS(ENABLE_DEFECTS)) u_dut (
      .gin(gate_in), .mode(defect_sel), .gout(dut_f)
   );

   aoi_gate_core #(.IN_W(IN_W), .ENABLE_DEFECTS(1'b0)) u_ref (
      .gin(gate_in), .mode(DEF_NONE), .gout(ref_f)
   );

   aoi_test_seq #(.IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(test_start), .sel(test_sel),
      .last(last), .mismatch(dut_f ^ ref_f),
      .busy(test_busy), .done(test_done), .detect(test_detect),
      .sel_q(sel_q), .idx(idx)
   );

   assign f_out = dut_f;

   always_comb begin
      if (!test_busy && defect_sel == 2'b00 && !in_vec[4] && !in_vec[1])
         assert_or_and_reduce_R6: assert (f_out == (in_vec[0] && (in_vec[3] || !in_vec[2])));
   end
endmodule

// File: tb/aoi_bist_gate_bench.sv
module aoi_bist_gate_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] in_vec = '0;
   logic [1:0] defect_sel = '0;
   logic       test_start = 1'b0;
   logic       test_sel = 1'b0;
   logic       f_out, test_busy, test_done, test_detect;
   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   aoi_bist_gate u_aoi_bist_gate (
      .clk(clk), .rst_n(rst_n), .in_vec(in_vec), .defect_sel(defect_sel),
      .test_start(test_start), .test_sel(test_sel), .f_out(f_out),
      .test_busy(test_busy), .test_done(test_done), .test_detect(test_detect)
   );

   function automatic int mj(input int x, input int y, input int z);
      return (x + y + z >= 2) ? 1 : 0;
   endfunction

   function automatic int model(input int mode, input int v);
      int a, b, c, d, e, t;
      a = (v >> 4) & 1; b = (v >> 3) & 1; c = (v >> 2) & 1;
      d = (v >> 1) & 1; e = v & 1;
      case (mode)
         0: return mj(mj(1 - a, b, 1 - c), d, e);
         1: return mj(b, d, e);
         2: return b;
         default: begin
            t = (1 - a) * b + b * (1 - c) + (1 - a) * (1 - b) * (1 - c);
            t = (t > 0) ? 1 : 0;
            if ((1 - d) * (1 - e) == 1) return 1;
            return ((d == 0 || e == 0) && t == 1) ? 1 : 0;
         end
      endcase
   endfunction

   function automatic int set_vec(input int sel, input int k);
      if (sel == 0) return (k == 0) ? 0 : 1;
      case (k)
         0: return 14;
         1: return 5;
         2: return 0;
         default: return 1;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run(input int sel, input int mode, input bit poke);
      int len, cnt, exp_det;
      len = (sel == 0) ? 2 : 4;
      exp_det = 0;
      for (int k = 0; k < len; k++)
         if (model(mode, set_vec(sel, k)) != model(0, set_vec(sel, k))) exp_det = 1;
      defect_sel = 2'(mode);
      test_sel = sel[0];
      test_start = 1'b1;
      @(negedge clk);
      test_start = 1'b0;
      cnt = 0;
      while (test_busy && cnt < 20) begin
         cnt++;
         if (poke && cnt == 2) test_start = 1'b1;
         @(negedge clk);
         test_start = 1'b0;
      end
      check(poke ? "R10 run length with start during run" : "R7 run length", cnt, len);
      check("R8 done after run", int'(test_done), 1);
      check("R9 detect flag", int'(test_detect), exp_det);
      @(negedge clk);
      check("R8 done held", int'(test_done), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 reset busy", int'(test_busy), 0);
      check("R8 reset done", int'(test_done), 0);
      check("R8 reset detect", int'(test_detect), 0);

      for (int m = 0; m < 4; m++) begin
         defect_sel = 2'(m);
         for (int v = 0; v < 32; v++) begin
            in_vec = 5'(v);
            #1;
            case (m)
               0: check("R1 fault-free function", int'(f_out), model(0, v));
               1: check("R2 B-majority defect", int'(f_out), model(1, v));
               2: check("R3 B-only defect", int'(f_out), model(2, v));
               default: check("R4 output-cell defect", int'(f_out), model(3, v));
            endcase
         end
      end

      defect_sel = 2'b00;
      for (int v = 0; v < 32; v++) begin
         int fa;
         in_vec = 5'(v); #1; fa = int'(f_out);
         in_vec = ~5'(v); #1;
         check("R5 complement symmetry", int'(f_out), 1 - fa);
      end
      for (int v = 0; v < 32; v++) begin
         if (((v >> 4) & 1) == 0 && ((v >> 1) & 1) == 0) begin
            in_vec = 5'(v); #1;
            check("R6 OR into AND", int'(f_out), (v & 1) & ((((v >> 3) & 1) | (1 - ((v >> 2) & 1)))));
         end
      end

      @(negedge clk);
      for (int s = 0; s < 2; s++)
         for (int m = 0; m < 4; m++)
            run(s, m, 1'b0);
      run(1, 3, 1'b1);
      run(0, 0, 1'b0);
      check("R9 fault-free never detects", int'(test_detect), 0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule